// File: doc/BRIEF.md
# Left-Shift Binary GCD Engine

This block computes the greatest common divisor of two unsigned W-bit operands. It does not use the right-shift reduction loop. Each reduction aligns the most significant one of the smaller operand with that of the larger operand, using a leading-zero count and a left shift. It then keeps the smaller of two non-negative residues. One residue undershoots the larger operand and the other overshoots it. After each step the pair is reordered so that the larger value sits in the upper slot. The loop ends when the lower slot reaches zero.

A problem is handed in with a valid/ready handshake and is accepted only while the engine is idle. The engine does one reduction per clock. It returns the result with a one-cycle done pulse. Alongside the result it gives the number of reduction steps used, which verification uses to bound and time the run. Only one problem is in flight at a time.

Top module: `gcd_lshift`

## Requirements
- R1: During and directly after a synchronous active-low reset, `in_ready` is 1 and `out_done` is 0.
- R2: `in_ready` is high only while idle. A problem is taken on a clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 in the following cycle.
- R3: Each accepted problem yields exactly one `out_done` pulse, one cycle wide. In that cycle `out_gcd` equals the greatest common divisor of the two operands, and `in_ready` is already 1.
- R4: If either operand is zero, the result is the other operand and `out_steps` is 0. Two zero operands give 0 with 0 steps.
- R5: Two equal non-zero operands give that value after exactly one step.
- R6: `out_steps` in the done cycle is the number of reduction steps. It never exceeds ceil(1.06·W)+1.
- R7: `out_done` is observed exactly `out_steps`+1 clock edges after the accepting edge.
- R8: Swapping the two operands changes neither the result nor the step count.
- R9: While a problem is in progress, `in_valid`, `in_a` and `in_b` are ignored and do not affect the result.
- R10: Operands with the top bit set give correct results. The doubled overshoot term is formed one bit wider than W and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Engine idle, able to take a pair |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| out_done | output | 1 | One-cycle pulse: result valid |
| out_gcd | output | W | Greatest common divisor |
| out_steps | output | $clog2(2W+2) | Reduction steps used by the last problem |

## Verification
A wrong residue choice or a missed reorder on any step shows up at the ports in one of two ways. Either `out_gcd` no longer matches an independent Euclidean reference, or the step count moves past its bound. Both are visible in the done cycle of that same problem. A sequencing fault shows up differently. It changes the distance between acceptance and the done pulse, or it lets `in_ready` rise too early. Either effect is visible within a cycle of the fault. Swapped operand pairs must match in result and in step count, which exposes asymmetric loading.

// File: rtl/gcd_lshift_pkg.sv
// Shared types and helpers for the left-shift GCD engine.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package gcd_lshift_pkg;

    // Sequencer states: waiting for work, or reducing.
    typedef enum logic [0:0] {
        GS_IDLE = 1'b0,
        GS_RUN  = 1'b1
    } gcd_state_e;

    // Upper bound on reduction steps for w-bit operands: ceil(1.06*w)+1.
    function automatic int step_limit(input int w);
        return (106 * w + 99) / 100 + 1;
    endfunction

endpackage

// File: rtl/gcd_lzc.sv
// Leading-zero counter.
// Returns the count of zero bits above the highest set bit of val.
// An all-zero input returns W. Purely combinational.
module gcd_lzc #(
    parameter  int W  = 32,
    localparam int LW = $clog2(W + 1)
) (
    input  logic [W-1:0]  val,
    output logic [LW-1:0] cnt
);

    // Scan upward; the highest set bit is the last one to write cnt.
    always_comb begin
        cnt = LW'(W);
        for (int i = 0; i < W; i++) begin
            if (val[i]) begin
                cnt = LW'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/gcd_step.sv
// One left-shift reduction step, combinational.
// Assumes hi >= lo > 0. Aligns lo under the MSB of hi, backs off by one
// position if the aligned value exceeds hi, keeps the smaller of the
// undershoot (hi - t) and overshoot (2t - hi) residues, then orders the
// new pair {lo, residue} so the larger lands in nx_hi.
module gcd_step #(
    parameter  int W  = 32,
    localparam int LW = $clog2(W + 1)
) (
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    output logic [W-1:0] nx_hi,
    output logic [W-1:0] nx_lo
);

    logic [LW-1:0] lz_hi;
    logic [LW-1:0] lz_lo;
    logic [LW-1:0] align_sh;
    logic [W-1:0]  shifted;
    logic [W-1:0]  trial;
    logic [W-1:0]  under_res;
    logic [W:0]    dbl_trial;
    logic [W:0]    over_res;
    logic          take_over;
    logic [W-1:0]  residue;

    gcd_lzc #(.W(W)) u_lz_hi (.val(hi), .cnt(lz_hi));
    gcd_lzc #(.W(W)) u_lz_lo (.val(lo), .cnt(lz_lo));

    // Align the MSB of lo with that of hi and back off if it overshoots.
    always_comb begin
        align_sh = lz_lo - lz_hi;
        shifted  = lo << align_sh;
        trial    = (shifted > hi) ? (shifted >> 1) : shifted;
    end

    // Form both residues; the doubled term is one bit wider than W.
    always_comb begin
        under_res = hi - trial;
        dbl_trial = {trial, 1'b0};
        over_res  = dbl_trial - {1'b0, hi};
        take_over = (over_res[W] == 1'b0) && (over_res[W-1:0] < under_res);
        residue   = take_over ? over_res[W-1:0] : under_res;
    end

    // Reorder so the larger of {lo, residue} is the new upper operand.
    always_comb begin
        if (lo >= residue) begin
            nx_hi = lo;
            nx_lo = residue;
        end else begin
            nx_hi = residue;
            nx_lo = lo;
        end
    end

endmodule

// File: rtl/gcd_lshift.sv
// Iterative left-shift binary GCD engine (top).
// Takes an operand pair on a valid/ready handshake while idle. Orders it
// so the larger operand is upper, then runs one gcd_step per clock
// until the lower operand is zero. Ends with a registered one-cycle
// done pulse carrying the result and the step count.
// Assumes: one problem at a time, synchronous active-low reset.
module gcd_lshift #(
    parameter  int W  = 32,
    localparam int CW = $clog2(2 * W + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [W-1:0]  in_a,
    input  logic [W-1:0]  in_b,
    output logic          out_done,
    output logic [W-1:0]  out_gcd,
    output logic [CW-1:0] out_steps
);
    import gcd_lshift_pkg::*;

    gcd_state_e    state_q;
    logic [W-1:0]  op_hi_q;
    logic [W-1:0]  op_lo_q;
    logic [CW-1:0] steps_q;
    logic          done_q;
    logic [W-1:0]  gcd_q;
    logic [W-1:0]  nx_hi;
    logic [W-1:0]  nx_lo;
    logic          a_is_hi;
    logic          lo_zero;

    gcd_step #(.W(W)) u_step (
        .hi    (op_hi_q),
        .lo    (op_lo_q),
        .nx_hi (nx_hi),
        .nx_lo (nx_lo)
    );

    // Entry ordering and termination detect.
    always_comb begin
        a_is_hi = (in_a >= in_b);
        lo_zero = (op_lo_q == '0);
    end

    // Sequencer: load, reduce one step per cycle, finish on zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
            op_hi_q <= '0;
            op_lo_q <= '0;
            steps_q <= '0;
            done_q  <= 1'b0;
            gcd_q   <= '0;
        end else begin
            case (state_q)
                GS_IDLE: begin
                    done_q <= 1'b0;
                    if (in_valid) begin
                        op_hi_q <= a_is_hi ? in_a : in_b;
                        op_lo_q <= a_is_hi ? in_b : in_a;
                        steps_q <= '0;
                        state_q <= GS_RUN;
                    end
                end
                GS_RUN: begin
                    if (lo_zero) begin
                        done_q  <= 1'b1;
                        gcd_q   <= op_hi_q;
                        state_q <= GS_IDLE;
                    end else begin
                        op_hi_q <= nx_hi;
                        op_lo_q <= nx_lo;
                        steps_q <= steps_q + 1'b1;
                    end
                end
                default: state_q <= GS_IDLE;
            endcase
        end
    end

    // Output drive.
    always_comb begin
        in_ready  = (state_q == GS_IDLE);
        out_done  = done_q;
        out_gcd   = gcd_q;
        out_steps = steps_q;
    end

endmodule

// File: rtl/gcd_lshift_chk.sv
// Port-level checker for gcd_lshift, attached with bind.
// Assumes the same W as the bound instance.
module gcd_lshift_chk #(
    parameter  int W  = 32,
    localparam int CW = $clog2(2 * W + 2)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_done,
    input logic [W-1:0]  out_gcd,
    input logic [CW-1:0] out_steps
);
    import gcd_lshift_pkg::*;

    localparam int LIMIT = step_limit(W);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !out_done));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> in_ready);

    // R6
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (int'(out_steps) <= LIMIT));

    // R4
    zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_gcd == '0) |-> (out_steps == '0));

endmodule

bind gcd_lshift gcd_lshift_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_done  (out_done),
    .out_gcd   (out_gcd),
    .out_steps (out_steps)
);

// File: tb/gcd_lshift_tb.sv
// Scoreboard bench for gcd_lshift: the driver queues expected items,
// the monitor pops and compares one per done pulse.
module gcd_lshift_tb;

    localparam int W  = 32;
    localparam int CW = $clog2(2 * W + 2);
    localparam int LIMIT = (106 * W + 99) / 100 + 1;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] g;
        int           exp_steps;
        bit           same_prev;
        int           acc;
        string        tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W-1:0]  in_a = '0;
    logic [W-1:0]  in_b = '0;
    logic          out_done;
    logic [W-1:0]  out_gcd;
    logic [CW-1:0] out_steps;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    int    prev_steps = 0;
    bit    finished = 1'b0;
    item_t sb[$];

    gcd_lshift #(.W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_done  (out_done),
        .out_gcd   (out_gcd),
        .out_steps (out_steps)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W-1:0] ref_gcd(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] x = a;
        logic [W-1:0] y = b;
        logic [W-1:0] r;
        while (y != 0) begin
            r = x % y;
            x = y;
            y = r;
        end
        return x;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: offer one pair, queue its expectation, optionally jam inputs while busy.
    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input int exp_steps,
                        input bit same_prev, input bit junk, input string tag);
        item_t it;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_a = a;
        in_b = b;
        in_valid = 1'b1;
        it.a = a; it.b = b; it.g = ref_gcd(a, b);
        it.exp_steps = exp_steps; it.same_prev = same_prev;
        it.acc = cyc + 1; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R2", "ready after accept", longint'(in_ready), 0);
        if (junk) begin
            for (int k = 0; k < 4; k++) begin
                if (!in_ready) begin
                    in_valid = 1'b1;
                    in_a = $urandom;
                    in_b = $urandom;
                end else begin
                    in_valid = 1'b0;
                end
                @(negedge clk);
            end
            in_valid = 1'b0;
        end
    endtask

    // Monitor: on each done pulse compare against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3", "unexpected done", 1, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(out_gcd == it.g, it.tag, "gcd value (R3)", longint'(out_gcd), longint'(it.g));
                check(int'(out_steps) <= LIMIT, "R6", "step bound", longint'(out_steps), LIMIT);
                check(cyc - it.acc == int'(out_steps) + 1, "R7", "done latency",
                      cyc - it.acc, longint'(out_steps) + 1);
                if (it.exp_steps >= 0)
                    check(int'(out_steps) == it.exp_steps, it.tag, "step count",
                          longint'(out_steps), it.exp_steps);
                if (it.same_prev)
                    check(int'(out_steps) == prev_steps, "R8", "swapped steps",
                          longint'(out_steps), prev_steps);
                prev_steps = int'(out_steps);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] g;
        logic [W-1:0] x;
        logic [W-1:0] y;
        repeat (3) @(negedge clk);
        // R1: reset state seen during reset and right after release
        check(in_ready == 1'b1 && out_done == 1'b0, "R1", "state in reset",
              longint'({in_ready, out_done}), 2);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1 && out_done == 1'b0, "R1", "state after reset",
              longint'({in_ready, out_done}), 2);

        // R4: zero operands
        send('0, '0, 0, 1'b0, 1'b0, "R4");
        send('0, 32'd12345, 0, 1'b0, 1'b0, "R4");
        send(32'd987654, '0, 0, 1'b0, 1'b0, "R4");
        send('0, 32'hFFFF_FFFF, 0, 1'b0, 1'b0, "R4");
        // R5: equal operands
        send(32'd1, 32'd1, 1, 1'b0, 1'b0, "R5");
        send(32'd777, 32'd777, 1, 1'b0, 1'b0, "R5");
        send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1'b0, 1'b0, "R5");
        // R10: top bit set
        send(32'hFFFF_FFFF, 32'hFFFF_FFFE, -1, 1'b0, 1'b0, "R10");
        send(32'h8000_0000, 32'hC000_0000, -1, 1'b0, 1'b0, "R10");
        send(32'hFFFF_FFFF, 32'h0000_0001, -1, 1'b0, 1'b0, "R10");
        send(32'hB504_F333, 32'h9E37_79B9, -1, 1'b0, 1'b0, "R10");
        send(32'h8000_0001, 32'h7FFF_FFFF, -1, 1'b0, 1'b0, "R10");
        // R8: operand order does not matter
        send(32'd1071, 32'd462, -1, 1'b0, 1'b0, "R8");
        send(32'd462, 32'd1071, -1, 1'b1, 1'b0, "R8");
        send(32'hDEAD_BEEF, 32'h1234_5678, -1, 1'b0, 1'b0, "R8");
        send(32'h1234_5678, 32'hDEAD_BEEF, -1, 1'b1, 1'b0, "R8");
        // R9: inputs jammed while busy
        send(32'hF0F0_F0F1, 32'h0F0F_0F0E, -1, 1'b0, 1'b1, "R9");
        send(32'h7654_3210, 32'h0123_4567, -1, 1'b0, 1'b1, "R9");
        // R3: random pairs
        for (int i = 0; i < 150; i++) begin
            send($urandom, $urandom, -1, 1'b0, (i % 5) == 0, "R3");
        end
        // R3: pairs with a large shared factor
        for (int i = 0; i < 40; i++) begin
            g = $urandom_range(1, 65535);
            x = $urandom_range(1, 65535);
            y = $urandom_range(1, 65535);
            send(g * x, g * y, -1, 1'b0, 1'b0, "R3");
        end
        // R3: powers of two
        for (int i = 0; i < W; i++) begin
            send(32'd1 << i, 32'd3 << (W - 1 - i), -1, 1'b0, 1'b0, "R3");
        end

        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule